// File: doc/BRIEF.md
# Four-Lane SD Data CRC16 Unit

This block keeps one 16-bit CRC per line of a four-bit SD data bus while payload nibbles pass through it, one nibble per valid strobe. Bit j of each nibble belongs to line j. Each line has its own CRC, and all four CRCs sit together in one interleaved 64-bit state register. Bit LANES*k+j of that register holds CRC bit (15-k) of line j. Each payload nibble is folded into every lane in a single cycle: the state shifts right by one nibble, and the result is XORed with an entry from a 16-entry table. The entry is chosen by the data nibble XOR the low state nibble.

A two-bit mode input selects what a strobe does.
- **Fold** absorbs a payload nibble into the CRCs.
- **Emit** serves the transmit side. Each strobe produces the next CRC nibble on a registered output, highest CRC bit first, and drains the state by one nibble.
- **Check** serves the receive side. The incoming CRC nibble is compared bit by bit with the computed value, and a sticky error flag is set for any lane that differs. A done flag rises once sixteen check nibbles have arrived.
- **Hold** ignores the strobe.

The surrounding framer clears the unit at the start of each block. It does not strobe the start and end nibbles, so neither of them enters the CRC. It also counts the block length.

Top module: `quad_crc16_lanes`

## Requirements
- R1: After reset, crc_vld, crc_nib, lane_err and chk_done are all zero, and the CRC state is zero: sixteen emit strobes right after reset return sixteen zero nibbles.
- R2: A high clr zeroes the CRC state, lane_err and chk_done on the next edge. clr takes priority over a strobe in the same cycle, and that strobe is lost.
- R3: A strobe with mode 0 (fold) updates, for each lane j, a CRC16 with polynomial x^16+x^12+x^5+1 (0x1021). The update shifts in nibble bit j most-significant-first, from an initial value of zero. A fold strobe produces no crc_vld pulse.
- R4: The i-th strobe (i = 0..15) with mode 1 (emit) causes crc_vld to be high for exactly the next cycle. On that cycle, bit j of crc_nib equals bit (15-i) of lane j's CRC.
- R5: Emitting also drains the state, so a 17th emit strobe returns nibble 0.
- R6: A strobe with mode 2 (check) compares nib_in with the next CRC nibble in the same order as R4. Any differing bit j sets lane_err[j] one cycle later. lane_err bits stay set until clr.
- R7: chk_done goes high in the cycle after the 16th check strobe since the last clear, and it stays high until clr. Check strobes after chk_done is high leave lane_err unchanged.
- R8: A strobe with mode 3 (hold) has no effect, and neither does a cycle with nib_vld low. The emitted CRC afterwards is unchanged.
- R9: Lanes are independent. A corrupted CRC bit on one line sets only that lane's error flag.
- R10: Folding 4096 nibbles of 0xF, which is 512 bytes of 0xFF on every line, yields a CRC of 0x7FA1 on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start-of-block clear of state and flags |
| nib_vld | input | 1 | Nibble strobe |
| mode | input | 2 | 0 fold, 1 emit, 2 check, 3 hold |
| nib_in | input | 4 | Data or received CRC nibble, bit j from line j |
| crc_vld | output | 1 | crc_nib holds an emitted CRC nibble |
| crc_nib | output | 4 | Emitted CRC nibble, bit j for line j |
| lane_err | output | 4 | Sticky per-lane CRC mismatch flags |
| chk_done | output | 1 | Sixteen check nibbles received; lane_err final |

## Verification
Faults in the interleaved state or the update table only show at the ports when the CRC leaves the block. Such a fault corrupts an emitted nibble or raises a false lane_err, and it does so up to sixteen strobes after the payload that caused it. The bench therefore emits or checks the full sixteen nibbles after every payload pattern. A wrong lane offset or table entry appears as a mismatch confined to the affected line's bit of crc_nib. A fault in the drain or the check counter shows in the 17th emitted nibble, or in chk_done rising one strobe early or late.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;
  typedef enum logic [1:0] {
    MD_FOLD  = 2'd0,
    MD_EMIT  = 2'd1,
    MD_CHECK = 2'd2,
    MD_HOLD  = 2'd3
  } qcrc_mode_e;

  localparam int DEF_LANES = 4;
  localparam int DEF_CRC_W = 16;
  localparam logic [15:0] DEF_POLY = 16'h1021;
endpackage

// File: rtl/qcrc_state.sv
module qcrc_state #(
  parameter int LANES = 4,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             fold_en,
  input  logic             shift_en,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] state_lo
);
  localparam int SW    = LANES * CRC_W;
  localparam int TBL_N = 1 << LANES;

  // Table entry: reflected polynomial spread to every LANES-th bit,
  // placed at the lane offset of each set index bit.
  function automatic logic [SW-1:0] tbl_entry(input int idx);
    logic [CRC_W-1:0] rp;
    logic [SW-1:0]    sp;
    logic [SW-1:0]    acc;
    for (int k = 0; k < CRC_W; k++) rp[k] = POLY[CRC_W-1-k];
    sp = '0;
    for (int k = 0; k < CRC_W; k++) sp[k*LANES] = rp[k];
    acc = '0;
    for (int j = 0; j < LANES; j++)
      if (idx[j]) acc = acc ^ (sp << j);
    return acc;
  endfunction

  logic [SW-1:0] tbl [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
    assign tbl[g] = tbl_entry(g);
  end

  logic [SW-1:0]    state_q;
  logic [LANES-1:0] idx;

  assign idx      = din ^ state_q[LANES-1:0];
  assign state_lo = state_q[LANES-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr)    state_q <= '0;
    else if (fold_en)  state_q <= (state_q >> LANES) ^ tbl[idx];
    else if (shift_en) state_q <= state_q >> LANES;
  end
endmodule

// File: rtl/qcrc_emit.sv
module qcrc_emit #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             emit_en,
  input  logic [LANES-1:0] state_lo,
  output logic             crc_vld,
  output logic [LANES-1:0] crc_nib
);
  always_ff @(posedge clk) begin
    if (rst) begin
      crc_vld <= 1'b0;
      crc_nib <= '0;
    end else begin
      crc_vld <= emit_en && !clr;
      if (emit_en && !clr) crc_nib <= state_lo;
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!emit_en || clr) |=> !crc_vld); // R4
endmodule

// File: rtl/qcrc_check.sv
module qcrc_check #(
  parameter int LANES = 4,
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             chk_en,
  input  logic [LANES-1:0] rx_nib,
  input  logic [LANES-1:0] state_lo,
  output logic [LANES-1:0] lane_err,
  output logic             chk_done
);
  localparam int CW = $clog2(CRC_W) + 1;
  localparam logic [CW-1:0] LAST = CW'(CRC_W - 1);

  logic [CW-1:0] cnt_q;
  logic          take;

  assign take = chk_en && !chk_done && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      lane_err <= '0;
      chk_done <= 1'b0;
    end else if (take) begin
      cnt_q    <= cnt_q + 1'b1;
      lane_err <= lane_err | (rx_nib ^ state_lo);
      if (cnt_q == LAST) chk_done <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((lane_err & $past(lane_err)) == $past(lane_err))); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (chk_done && !clr) |=> chk_done); // R7
  AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (chk_done && !clr) |=> $stable(lane_err)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(CRC_W)); // R7
endmodule

// File: rtl/quad_crc16_lanes.sv
module quad_crc16_lanes
  import qcrc_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int CRC_W = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             nib_vld,
  input  logic [1:0]       mode,
  input  logic [LANES-1:0] nib_in,
  output logic             crc_vld,
  output logic [LANES-1:0] crc_nib,
  output logic [LANES-1:0] lane_err,
  output logic             chk_done
);
  qcrc_mode_e       md;
  logic             fold_en, emit_en, chk_en, shift_en;
  logic [LANES-1:0] state_lo;

  assign md       = qcrc_mode_e'(mode);
  assign fold_en  = nib_vld && (md == MD_FOLD);
  assign emit_en  = nib_vld && (md == MD_EMIT);
  assign chk_en   = nib_vld && (md == MD_CHECK);
  assign shift_en = emit_en || (chk_en && !chk_done);

  qcrc_state #(.LANES(LANES), .CRC_W(CRC_W), .POLY(POLY)) state_i (
    .clk(clk), .rst(rst), .clr(clr), .fold_en(fold_en),
    .shift_en(shift_en), .din(nib_in), .state_lo(state_lo)
  );

  qcrc_emit #(.LANES(LANES)) emit_i (
    .clk(clk), .rst(rst), .clr(clr), .emit_en(emit_en),
    .state_lo(state_lo), .crc_vld(crc_vld), .crc_nib(crc_nib)
  );

  qcrc_check #(.LANES(LANES), .CRC_W(CRC_W)) check_i (
    .clk(clk), .rst(rst), .clr(clr), .chk_en(chk_en), .rx_nib(nib_in),
    .state_lo(state_lo), .lane_err(lane_err), .chk_done(chk_done)
  );

  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (lane_err == '0 && !chk_done && !crc_vld)); // R2
  AST_FOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (nib_vld && (md == MD_FOLD || md == MD_HOLD)) |=> !crc_vld); // R3
  AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    crc_vld |-> $past(nib_vld && md == MD_EMIT)); // R4
endmodule

// File: tb/quad_crc16_lanes_tb_top.sv
module quad_crc16_lanes_tb_top;
  import qcrc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, clr, nib_vld;
  logic [1:0] mode;
  logic [3:0] nib_in, crc_nib, lane_err;
  logic crc_vld, chk_done;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] expq [$];
  logic [15:0] mcrc [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_crc16_lanes dut_i (
    .clk(clk), .rst(rst), .clr(clr), .nib_vld(nib_vld), .mode(mode),
    .nib_in(nib_in), .crc_vld(crc_vld), .crc_nib(crc_nib),
    .lane_err(lane_err), .chk_done(chk_done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pop an expected nibble for every emitted one
  always @(negedge clk) begin
    if (!rst && crc_vld) begin
      if (expq.size() == 0) check("R4 unexpected crc_vld", 64'(crc_nib), 64'hx);
      else check("R4 emitted nibble", 64'(crc_nib), 64'(expq.pop_front()));
    end
  end

  task automatic put(input qcrc_mode_e m, input logic [3:0] n);
    nib_vld = 1'b1; mode = m; nib_in = n;
    @(negedge clk);
    nib_vld = 1'b0; mode = MD_HOLD; nib_in = '0;
  endtask

  task automatic mreset();
    for (int j = 0; j < 4; j++) mcrc[j] = '0;
  endtask

  task automatic do_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0; mreset();
  endtask

  task automatic fold(input logic [3:0] n);
    for (int j = 0; j < 4; j++) begin
      logic fb;
      fb = n[j] ^ mcrc[j][15];
      mcrc[j] = {mcrc[j][14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    put(MD_FOLD, n);
  endtask

  function automatic logic [3:0] mnib(input int i);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) r[j] = mcrc[j][15-i];
    return r;
  endfunction

  task automatic emit16();
    for (int i = 0; i < 16; i++) begin
      expq.push_back(mnib(i));
      put(MD_EMIT, 4'h0);
    end
    mreset();
  endtask

  // Check 16 nibbles; flip bit mask 'fm' in nibble 'fi'
  task automatic chk16(input int fi, input logic [3:0] fm);
    for (int i = 0; i < 16; i++) begin
      check("R7 done not early", 64'(chk_done), 64'd0);
      put(MD_CHECK, mnib(i) ^ ((i == fi) ? fm : 4'h0));
    end
    mreset();
  endtask

  task automatic payload(input int len, input int seed);
    for (int i = 0; i < len; i++) fold(4'((i * 7 + seed * 13 + (i >> 2)) ^ seed));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; nib_vld = 1'b0; mode = MD_HOLD; nib_in = '0;
    mreset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 crc_vld", 64'(crc_vld), 64'd0);
    check("R1 crc_nib", 64'(crc_nib), 64'd0);
    check("R1 lane_err", 64'(lane_err), 64'd0);
    check("R1 chk_done", 64'(chk_done), 64'd0);
    emit16();                                  // R1 zero state
    // R3/R4 short payload (8 nibbles = 4 bytes)
    do_clr(); payload(8, 1); emit16();
    // R5 drain: 17th emit gives zero
    expq.push_back(4'h0); put(MD_EMIT, 4'h0);
    // R3 longer payload, other pattern
    do_clr(); payload(1024, 5); emit16();
    // R8 hold strobes and idle cycles ignored
    do_clr(); payload(20, 3);
    for (int i = 0; i < 6; i++) put(MD_HOLD, 4'(i * 5 + 1));
    repeat (4) @(negedge clk);
    check("R8 no output on hold", 64'(crc_vld), 64'd0);
    payload(4, 9); emit16();
    // R2 clr priority over a fold strobe
    do_clr(); payload(10, 2);
    clr = 1'b1; nib_vld = 1'b1; mode = MD_FOLD; nib_in = 4'hA;
    @(negedge clk);
    clr = 1'b0; nib_vld = 1'b0; mode = MD_HOLD; mreset();
    emit16();
    // R6/R7 receive with correct CRC
    do_clr(); payload(40, 4); chk16(-1, 4'h0);
    check("R7 chk_done after 16", 64'(chk_done), 64'd1);
    check("R6 no error on good CRC", 64'(lane_err), 64'd0);
    // R9 corrupt lane 2 only
    do_clr(); payload(40, 6); chk16(7, 4'b0100);
    check("R9 only lane 2 flagged", 64'(lane_err), 64'b0100);
    check("R7 chk_done", 64'(chk_done), 64'd1);
    // R7 strobes after done ignored
    for (int i = 0; i < 4; i++) put(MD_CHECK, 4'hB);
    check("R7 err frozen after done", 64'(lane_err), 64'b0100);
    // R6 sticky multi-lane errors
    do_clr(); payload(12, 8); chk16(0, 4'b1001);
    check("R6 lanes 0 and 3 flagged", 64'(lane_err), 64'b1001);
    // R2 clr zeroes flags
    do_clr();
    check("R2 lane_err cleared", 64'(lane_err), 64'd0);
    check("R2 chk_done cleared", 64'(chk_done), 64'd0);
    // R10 known vector: 512 bytes of 0xFF on every line -> 0x7FA1
    for (int i = 0; i < 4096; i++) put(MD_FOLD, 4'hF);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] kv;
      kv = 16'h7FA1;
      expq.push_back(kv[15-i] ? 4'hF : 4'h0);
      put(MD_EMIT, 4'h0);
    end
    repeat (3) @(negedge clk);
    check("R4 queue drained", 64'(expq.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule